// File: doc/BRIEF.md
# Fractional-Rate Serial Transmitter

This block sends asynchronous serial frames whose bit period need not be a whole number of system clocks. The period is given as a fixed-point count of clocks per bit with sixteen integer bits and six kept fraction bits. Every bit lasts the integer part of that count. A six-bit fraction accumulator adds one extra clock to a bit whenever it carries. Bit edges therefore always fall on system clock edges, and they jitter by at most one clock. Over a frame the average rate matches the programmed fraction. The accumulator is cleared at the start of every frame, so rounding error never carries from one frame into the next.

A 32-bit configuration word holds the period in the usual 16.16 layout. Its lowest bits are reused for the frame length, and the fraction bits below the kept six are ignored. A one-word holding buffer sits in front of the shifter. Software writes a word whenever `ready` is high, so it can queue the next word while the current frame is still going out. A queued word starts right after the stop bit of the current frame, with no idle clock in between. Writing an alternating bit pattern again and again gives a continuous square wave on the line.

Top module: `fracBaudTx`

## Requirements
- R1: After reset with `enable` high, and whenever no frame is in flight, `txOut` is 1 and `ready` is 1.
- R2: A `dataWr` pulse while `ready` is 1 loads `dataIn` into the buffer, and `ready` is 0 in the next cycle. The start bit appears on `txOut` one clock after the write is taken. `ready` returns to 1 in that same cycle, because the word has moved into the shifter.
- R3: A frame is one start bit at 0, then N data bits sent least significant bit first, then one stop bit at 1. N equals `cfgWord[4:0]` plus one, giving 1 to 32 bits.
- R4: Let I be `cfgWord[31:16]` and F be `cfgWord[15:10]`. Bit k of a frame (k = 0 for the start bit) lasts I clocks, plus one when the running sum F·(k+1) crosses a multiple of 64 on that bit. `cfgWord[9:5]` has no effect on timing.
- R5: The fraction accumulator starts again from zero at every frame, including frames sent back to back.
- R6: If I is below 2, every bit lasts exactly 2 clocks and F is ignored. Two clocks is the shortest possible bit.
- R7: A word written while a frame is being sent starts its start bit in the first clock after the current stop bit ends.
- R8: A `dataWr` pulse while `ready` is 0 is dropped. The buffered word is kept and no extra frame is sent.
- R9: While `enable` is 0, `txOut` is 1 and `ready` is 0, writes are ignored, and the buffer and the frame in flight are discarded. After `enable` returns to 1, the line stays idle until a new word is written.
- R10: `cfgWord` is captured when a frame starts. Changing it during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low clears the block and holds the line idle |
| cfgWord | input | 32 | Clocks per bit in 16.16 form; bits [4:0] give the data length minus one |
| dataIn | input | 32 | Word to send, least significant bit first |
| dataWr | input | 1 | Write strobe for `dataIn` |
| ready | output | 1 | The holding buffer is empty and a write will be taken |
| txOut | output | 1 | Serial line, idles high |

## Verification
Each result has a fixed due cycle. A write taken at clock edge k drops `ready` just after edge k. The start bit and the return of `ready` both appear just after edge k+1. From there each bit holds for its computed length, and a queued frame follows the previous stop bit with no gap. A change of `enable` shows on `txOut` one edge later. The bench drives inputs and samples outputs on falling edges. It builds every frame's expected waveform one clock at a time from I, F and N, with the accumulator restarted per frame. It checks each bit over exactly its expected number of clocks, so a bit that is one clock early or late fails.

// File: rtl/ftxPkg.sv
package ftxPkg;

  typedef struct packed {
    logic loadFrame;
    logic shiftBit;
    logic stopBit;
  } txStrobes_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_STOP
  } txPhase_t;

endpackage

// File: rtl/ftxControl.sv
module ftxControl
  import ftxPkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [INT_W-1:0]  cfgInt,
  input  logic [FRAC_W-1:0] cfgFrac,
  input  logic [LEN_W-1:0]  cfgLenM1,
  input  logic              holdValid,
  output txStrobes_t        strobes
);

  localparam int CNT_W = INT_W + 1;
  localparam logic [INT_W-1:0] MIN_INT = INT_W'(2);

  txPhase_t          phase;
  logic [CNT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [LEN_W-1:0]  bitsLeft;
  logic [INT_W-1:0]  latInt;
  logic [FRAC_W-1:0] latFrac;
  logic [LEN_W-1:0]  latLen;

  logic [INT_W-1:0]  newInt;
  logic [FRAC_W-1:0] newFrac;
  logic [FRAC_W:0]   fracSum;
  logic [CNT_W-1:0]  nextLen;
  logic              bitEnd;

  always_comb begin
    newInt  = (cfgInt < MIN_INT) ? MIN_INT : cfgInt;
    newFrac = (cfgInt < MIN_INT) ? '0 : cfgFrac;
    fracSum = {1'b0, acc} + {1'b0, latFrac};
    nextLen = {1'b0, latInt} + CNT_W'(fracSum[FRAC_W]);
    bitEnd  = (phase != PH_IDLE) && (cnt == '0);

    strobes.loadFrame = enable && holdValid &&
                        ((phase == PH_IDLE) || ((phase == PH_STOP) && bitEnd));
    strobes.shiftBit  = enable && bitEnd &&
                        ((phase == PH_START) || ((phase == PH_DATA) && (bitsLeft != '0)));
    strobes.stopBit   = enable && bitEnd && (phase == PH_DATA) && (bitsLeft == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      acc      <= '0;
      bitsLeft <= '0;
      latInt   <= MIN_INT;
      latFrac  <= '0;
      latLen   <= '0;
    end else if (strobes.loadFrame) begin
      phase    <= PH_START;
      latInt   <= newInt;
      latFrac  <= newFrac;
      latLen   <= cfgLenM1;
      acc      <= newFrac;
      cnt      <= {1'b0, newInt} - CNT_W'(1);
    end else if (bitEnd) begin
      acc <= fracSum[FRAC_W-1:0];
      cnt <= nextLen - CNT_W'(1);
      unique case (phase)
        PH_START: begin
          phase    <= PH_DATA;
          bitsLeft <= latLen;
        end
        PH_DATA: begin
          if (bitsLeft == '0) phase <= PH_STOP;
          else                bitsLeft <= bitsLeft - LEN_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end else if (phase != PH_IDLE) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadFrame, strobes.shiftBit, strobes.stopBit}));

  p_min_bit_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadFrame || strobes.shiftBit || strobes.stopBit) |=>
      !(strobes.loadFrame || strobes.shiftBit || strobes.stopBit));

  p_idle_no_shift_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> !(strobes.shiftBit || strobes.stopBit));

endmodule

// File: rtl/ftxDatapath.sv
module ftxDatapath
  import ftxPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataWr,
  input  txStrobes_t        strobes,
  output logic              holdValid,
  output logic              ready,
  output logic              txOut
);

  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] shiftReg;
  logic              txReg;

  assign ready = enable && !holdValid;
  assign txOut = txReg;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      holdValid <= 1'b0;
      holdData  <= '0;
      shiftReg  <= '0;
      txReg     <= 1'b1;
    end else begin
      if (strobes.loadFrame) begin
        shiftReg  <= holdData;
        holdValid <= 1'b0;
        txReg     <= 1'b0;
      end else if (dataWr && !holdValid) begin
        holdData  <= dataIn;
        holdValid <= 1'b1;
      end
      if (strobes.shiftBit) begin
        txReg    <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end
      if (strobes.stopBit) begin
        txReg <= 1'b1;
      end
    end
  end

  p_full_keeps_word_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && holdValid && !strobes.loadFrame) |=>
      (!enable || (holdValid && $stable(holdData))));

endmodule

// File: rtl/fracBaudTx.sv
module fracBaudTx
  import ftxPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic [INT_W+15:0]     cfgWord,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic                  dataWr,
  output logic                  ready,
  output logic                  txOut
);

  localparam int LEN_W = $clog2(DATA_W);
  localparam int FRAC_LO = 16 - FRAC_W;

  txStrobes_t strobes;
  logic       holdValid;

  ftxControl #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W),
    .LEN_W (LEN_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .cfgInt   (cfgWord[INT_W+15:16]),
    .cfgFrac  (cfgWord[15:FRAC_LO]),
    .cfgLenM1 (cfgWord[LEN_W-1:0]),
    .holdValid(holdValid),
    .strobes  (strobes)
  );

  ftxDatapath #(
    .DATA_W(DATA_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .dataIn   (dataIn),
    .dataWr   (dataWr),
    .strobes  (strobes),
    .holdValid(holdValid),
    .ready    (ready),
    .txOut    (txOut)
  );

  p_disable_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (txOut && !holdValid));

  p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && ready) |=> !ready);

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadFrame |=> (!enable || !txOut));

  p_bit_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !(strobes.loadFrame || strobes.shiftBit || strobes.stopBit)) |=>
      (!enable || $stable(txOut)));

endmodule

// File: tb/sim_fracBaudTx.sv
`timescale 1ns/1ps
module sim_fracBaudTx;

  logic        clk = 1'b0;
  logic        rstN;
  logic        enable;
  logic [31:0] cfgWord;
  logic [31:0] dataIn;
  logic        dataWr;
  logic        ready;
  logic        txOut;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  fracBaudTx u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWord(cfgWord),
    .dataIn(dataIn), .dataWr(dataWr), .ready(ready), .txOut(txOut)
  );

  localparam int NVEC = 7;
  localparam logic [63:0] VECS [NVEC] = '{
    {32'h0003_5407, 32'h0000_00A5},   // R4 3.33 clk/bit, 8 bits
    {32'h0003_541F, 32'h5555_5555},   // R3 32 bits, square wave
    {32'h0004_0000, 32'h0000_0001},   // R3 single data bit
    {32'h0002_800F, 32'h0000_1234},   // R4 2.5 clk/bit, 16 bits
    {32'h0001_0003, 32'h0000_0009},   // R6 integer 1 -> 2 clocks
    {32'h0000_03E7, 32'h0000_003C},   // R6 and R4: bits [9:5] ignored
    {32'h0005_FC02, 32'h0000_0005}    // R4 fraction 63/64
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeWord(input logic [31:0] w);
    @(negedge clk);
    dataIn = w;
    dataWr = 1'b1;
    @(negedge clk);
    dataWr = 1'b0;
    check(ready == 1'b0, "R2 ready low after write", 32'(ready), 32'd0);
  endtask

  task automatic expectFrame(input logic [31:0] cfg, input logic [31:0] data,
                             input bit doNext, input logic [31:0] nextData,
                             input bit doCfg, input logic [31:0] newCfg,
                             input string tag);
    int iv = int'(cfg[31:16]);
    int fv = int'(cfg[15:10]);
    int nBits = int'(cfg[4:0]) + 1;
    int acc = 0;
    int idx = 0;
    if (iv < 2) begin
      iv = 2;
      fv = 0;
    end
    for (int k = 0; k < nBits + 2; k++) begin
      int s = acc + fv;
      int len = iv + (s >> 6);
      logic expV;
      logic badV = 1'b0;
      bit ok = 1'b1;
      acc = s & 63;
      expV = (k == 0) ? 1'b0 : (k == nBits + 1) ? 1'b1 : data[k-1];
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        if (txOut !== expV) begin
          ok = 1'b0;
          badV = txOut;
        end
        if (idx == 0)
          check(ready == 1'b1, "R2 ready back at start bit", 32'(ready), 32'd1);
        if (idx == 0 && doNext) begin
          dataIn = nextData;
          dataWr = 1'b1;
        end else begin
          dataWr = 1'b0;
        end
        if (idx == 3 && doCfg) cfgWord = newCfg;
        idx++;
      end
      check(ok, $sformatf("%s bit %0d", tag, k), 32'(badV), 32'(expV));
    end
  endtask

  task automatic checkIdle(input int n, input string tag);
    bit ok = 1'b1;
    logic [1:0] seen = 2'b11;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (txOut !== 1'b1 || ready !== 1'b1) begin
        ok = 1'b0;
        seen = {txOut, ready};
      end
    end
    check(ok, $sformatf("%s idle line/ready", tag), 32'(seen), 32'd3);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    enable = 1'b1;
    cfgWord = 32'h0003_0007;
    dataIn = '0;
    dataWr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txOut == 1'b1 && ready == 1'b1, "R1 reset state", {30'd0, txOut, ready}, 32'd3);

    for (int v = 0; v < NVEC; v++) begin
      cfgWord = VECS[v][63:32];
      writeWord(VECS[v][31:0]);
      expectFrame(VECS[v][63:32], VECS[v][31:0], 1'b0, '0, 1'b0, '0,
                  $sformatf("R3/R4 vec%0d", v));
      checkIdle(4, "R1");
    end

    // R7 and R5: queued frame follows at once and restarts the fraction
    cfgWord = 32'h0003_5407;
    writeWord(32'h0000_00C3);
    expectFrame(cfgWord, 32'h0000_00C3, 1'b1, 32'h0000_003C, 1'b0, '0, "R7 first");
    expectFrame(cfgWord, 32'h0000_003C, 1'b0, '0, 1'b0, '0, "R5 second");
    checkIdle(6, "R7");

    // R8: write while the buffer is full is dropped
    writeWord(32'h0000_0081);
    dataIn = 32'h0000_00FF;
    dataWr = 1'b1;
    expectFrame(cfgWord, 32'h0000_0081, 1'b0, '0, 1'b0, '0, "R8 frame");
    checkIdle(40, "R8 no extra frame");

    // R10: configuration captured at frame start
    cfgWord = 32'h0003_0007;
    writeWord(32'h0000_005A);
    expectFrame(32'h0003_0007, 32'h0000_005A, 1'b0, '0, 1'b1, 32'h0005_0003, "R10 old cfg");
    checkIdle(4, "R10");
    writeWord(32'h0000_000B);
    expectFrame(32'h0005_0003, 32'h0000_000B, 1'b0, '0, 1'b0, '0, "R10 new cfg");
    checkIdle(4, "R10");

    // R9: disable clears frame and buffer
    cfgWord = 32'h0004_0007;
    writeWord(32'h0000_0000);
    repeat (3) @(negedge clk);
    writeWord(32'h0000_0000);
    enable = 1'b0;
    @(negedge clk);
    check(txOut == 1'b1 && ready == 1'b0, "R9 disabled outputs",
          {30'd0, txOut, ready}, 32'd2);
    dataIn = 32'h0000_0000;
    dataWr = 1'b1;
    @(negedge clk);
    dataWr = 1'b0;
    enable = 1'b1;
    checkIdle(60, "R9 nothing pending");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule